// File: doc/BRIEF.md
# Nibble-RAM Bank Controller

This block is the banking controller of a plug-in program cartridge. It watches a 16-bit CPU address bus. It turns reads in the switchable upper half of the program space into physical ROM addresses. It also holds a small internal store of 4-bit words that the CPU sees in an external-RAM window. The ROM itself sits outside the block and is indexed by `rom_addr_o`. The 512-nibble store is inside the block.

Control writes all land in the lower 16 KB of the address space. Address bit 8 picks the target. When it is set, the write loads the 4-bit bank number. When it is clear, the write opens or closes the RAM window. Reads from the window return each stored nibble with its upper four data bits driven high. The window repeats the 512-entry store across its whole 8 KB span. Reads and address mapping are combinational. Register and store updates take effect on the rising clock edge of a cycle with `wr_i` high.

Top module: `nibble_bank_mapper`

## Requirements
- R1: A write to 0x0000–0x3FFF with address bit 8 = 1 loads the bank register with `wdata_i[3:0]`; a value of 0 is loaded as 1. The upper data bits are ignored.
- R2: A write to 0x0000–0x3FFF with address bit 8 = 0 enables the RAM window when `wdata_i[3:0]` is 4'hA and disables it for any other nibble. The upper data bits are ignored.
- R3: The store has 512 nibbles, and any address in 0xA000–0xBFFF selects entry `addr_i[8:0]`, so the window mirrors the store every 0x200 bytes.
- R4: While the window is enabled, a read there gives `{4'hF, nibble}` on `rdata_o`. While it is disabled, the read gives 8'hFF.
- R5: An enabled write in the window stores `wdata_i[3:0]` only. A write while the window is disabled leaves the store unchanged.
- R6: For an address in 0x4000–0x7FFF, `rom_addr_o` = (bank × 0x4000 + (addr − 0x4000)) mod 2^ROM_AW. The default ROM_AW is 17 (128 KB), so banks 8–15 fold onto banks 0–7.
- R7: For an address in 0x0000–0x3FFF, `rom_addr_o` equals the address, taken mod 2^ROM_AW.
- R8: Writes to 0x4000–0x7FFF change neither the bank register nor the window enable.
- R9: Reset (`rst_ni` low, asynchronous) sets the bank to 1 and disables the window. Store contents survive reset.
- R10: `rom_sel_o` is high exactly for 0x0000–0x7FFF, and `ram_sel_o` is high exactly for 0xA000–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rom_addr_o | output | ROM_AW (17) | Physical ROM byte address |
| rom_sel_o | output | 1 | Address lies in program space |
| ram_sel_o | output | 1 | Address lies in the RAM window |
| rdata_o | output | 8 | Read data for the RAM window |

## Verification
The checker assumes that `addr_i`, `wdata_i` and `wr_i` are stable across each rising edge. It also assumes that the store is read only after a write has defined the entry, because store contents are never cleared. The bench meets both assumptions. It changes inputs only on falling edges, and it writes every store location before reading it back, including across the mid-run reset. Control writes use bit-8 patterns and upper data nibbles chosen so that any decode which looks at the wrong bits produces a visible difference.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  typedef enum logic [1:0] {
    RGN_CTRL   = 2'd0,  // 0x0000-0x3FFF: fixed ROM, control writes
    RGN_BANKED = 2'd1,  // 0x4000-0x7FFF: switchable ROM
    RGN_NRAM   = 2'd2,  // 0xA000-0xBFFF: nibble window
    RGN_NONE   = 2'd3
  } region_e;

  localparam int unsigned WIN_W = 14;   // 16 KB ROM window
  localparam logic [3:0] EN_KEY = 4'hA;
endpackage

// File: rtl/nbm_decode.sv
module nbm_decode
  import nbm_pkg::*;
(
  input  logic [15:0] addr_i,
  output region_e     region_o
);
  always_comb begin
    unique case (addr_i[15:13])
      3'b000, 3'b001: region_o = RGN_CTRL;
      3'b010, 3'b011: region_o = RGN_BANKED;
      3'b101:         region_o = RGN_NRAM;
      default:        region_o = RGN_NONE;
    endcase
  end
endmodule

// File: rtl/nbm_regs.sv
module nbm_regs
  import nbm_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              pick_bank_i,
  input  logic [3:0]        nib_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              ram_en_o
);
  logic [BANK_W-1:0] nib_ext;
  logic [BANK_W-1:0] bank_d;

  generate
    if (BANK_W > 4) begin : g_wide
      assign nib_ext = {{(BANK_W-4){1'b0}}, nib_i};
    end else begin : g_narrow
      assign nib_ext = nib_i[BANK_W-1:0];
    end
  endgenerate

  // bank 0 is never selectable
  assign bank_d = (nib_ext == '0) ? BANK_W'(1) : nib_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o   <= BANK_W'(1);
      ram_en_o <= 1'b0;
    end else if (ctrl_wr_i) begin
      if (pick_bank_i) bank_o   <= bank_d;
      else             ram_en_o <= (nib_i == EN_KEY);
    end
  end
endmodule

// File: rtl/nbm_nibble_ram.sv
module nbm_nibble_ram #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [3:0]    nib_i,
  input  logic          en_i,
  output logic [7:0]    rdata_o
);
  logic [3:0] mem_q [DEPTH];

  // contents are retained across reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= nib_i;
  end

  assign rdata_o = en_i ? {4'hF, mem_q[idx_i]} : 8'hFF;
endmodule

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper
  import nbm_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned RAM_DEPTH = 512,
  parameter int unsigned ROM_AW    = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic [7:0]        rdata_o
);
  localparam int unsigned RAM_AW = $clog2(RAM_DEPTH);
  localparam int unsigned FULL_W = BANK_W + WIN_W;

  region_e           region;
  logic [BANK_W-1:0] bank_q;
  logic              ram_en_q;
  logic [FULL_W-1:0] full_addr;
  logic [7:0]        ram_rdata;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[7:4];

  nbm_decode u_dec (
    .addr_i   (addr_i),
    .region_o (region)
  );

  nbm_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (wr_i && region == RGN_CTRL),
    .pick_bank_i (addr_i[8]),
    .nib_i       (wdata_i[3:0]),
    .bank_o      (bank_q),
    .ram_en_o    (ram_en_q)
  );

  nbm_nibble_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_i && region == RGN_NRAM && ram_en_q),
    .idx_i   (addr_i[RAM_AW-1:0]),
    .nib_i   (wdata_i[3:0]),
    .en_i    (ram_en_q),
    .rdata_o (ram_rdata)
  );

  assign full_addr = (region == RGN_BANKED) ? {bank_q, addr_i[WIN_W-1:0]}
                                            : {{BANK_W{1'b0}}, addr_i[WIN_W-1:0]};

  // power-of-two capacity: wrap by truncation
  generate
    if (ROM_AW <= FULL_W) begin : g_wrap
      assign rom_addr_o = full_addr[ROM_AW-1:0];
    end else begin : g_pad
      assign rom_addr_o = {{(ROM_AW-FULL_W){1'b0}}, full_addr};
    end
  endgenerate

  assign rom_sel_o = (region == RGN_CTRL) || (region == RGN_BANKED);
  assign ram_sel_o = (region == RGN_NRAM);
  assign rdata_o   = ram_sel_o ? ram_rdata : 8'hFF;
endmodule

// File: rtl/nbm_chk.sv
module nbm_chk #(
  parameter int unsigned BANK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_i,
  input logic              rom_sel_o,
  input logic              ram_sel_o,
  input logic [7:0]        rdata_o,
  input logic [BANK_W-1:0] bank_q,
  input logic              ram_en_q
);
  logic in_ctrl, in_banked;
  assign in_ctrl   = (addr_i[15:14] == 2'b00);
  assign in_banked = (addr_i[15:14] == 2'b01);

  // R1
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && in_ctrl && addr_i[8] && wdata_i[3:0] != 4'h0
    |=> bank_q == BANK_W'($past(wdata_i[3:0])));

  // R1
  bank_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_q != '0);

  // R2
  enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && in_ctrl && !addr_i[8]
    |=> ram_en_q == ($past(wdata_i[3:0]) == 4'hA));

  // R4
  closed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o && !ram_en_q |-> rdata_o == 8'hFF);

  // R4
  open_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o && ram_en_q |-> rdata_o[7:4] == 4'hF);

  // R8
  banked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && in_banked |=> $stable(bank_q) && $stable(ram_en_q));

  // R10
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o}));
endmodule

bind nibble_bank_mapper nbm_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_i      (wr_i),
  .rom_sel_o (rom_sel_o),
  .ram_sel_o (ram_sel_o),
  .rdata_o   (rdata_o),
  .bank_q    (bank_q),
  .ram_en_q  (ram_en_q)
);

// File: tb/nibble_bank_mapper_test.sv
module nibble_bank_mapper_test;
  localparam int ROM_AW = 17;
  localparam int NV     = 30;
  // op: 0 write, 1 check rdata, 2 check rom_addr, 3 check {rom_sel,ram_sel}
  localparam logic [46:0] VEC [NV] = '{
    {2'd2, 4'd9,  16'h4000, 8'h00, 17'h04000},  // R9 bank 1 after reset
    {2'd1, 4'd9,  16'hA000, 8'h00, 17'h000FF},  // R9 window closed
    {2'd0, 4'd1,  16'h2100, 8'h05, 17'h0},
    {2'd2, 4'd6,  16'h4123, 8'h00, 17'h14123},  // R6
    {2'd0, 4'd1,  16'h2100, 8'hF0, 17'h0},      // R1 zero -> 1
    {2'd2, 4'd1,  16'h7FFF, 8'h00, 17'h07FFF},
    {2'd0, 4'd2,  16'h0000, 8'h3A, 17'h0},      // R2 enable
    {2'd0, 4'd5,  16'hA005, 8'h97, 17'h0},
    {2'd1, 4'd5,  16'hA005, 8'h00, 17'h000F7},  // R5 low nibble only
    {2'd1, 4'd3,  16'hA205, 8'h00, 17'h000F7},  // R3 mirror
    {2'd1, 4'd3,  16'hBE05, 8'h00, 17'h000F7},  // R3 mirror
    {2'd0, 4'd8,  16'h4100, 8'h03, 17'h0},
    {2'd0, 4'd8,  16'h6000, 8'h00, 17'h0},
    {2'd2, 4'd8,  16'h4000, 8'h00, 17'h04000},  // R8 bank kept
    {2'd1, 4'd8,  16'hA005, 8'h00, 17'h000F7},  // R8 enable kept
    {2'd0, 4'd1,  16'h2100, 8'h0C, 17'h0},
    {2'd2, 4'd6,  16'h4010, 8'h00, 17'h10010},  // R6 wrap
    {2'd2, 4'd7,  16'h1234, 8'h00, 17'h01234},  // R7
    {2'd0, 4'd2,  16'h0000, 8'h0B, 17'h0},
    {2'd1, 4'd4,  16'hA005, 8'h00, 17'h000FF},  // R4 closed
    {2'd0, 4'd5,  16'hA005, 8'h01, 17'h0},      // R5 ignored
    {2'd0, 4'd2,  16'h3E00, 8'h1A, 17'h0},
    {2'd1, 4'd5,  16'hA005, 8'h00, 17'h000F7},  // R5 R2
    {2'd0, 4'd1,  16'h3F00, 8'h02, 17'h0},
    {2'd2, 4'd1,  16'h4000, 8'h00, 17'h08000},  // R1
    {2'd3, 4'd10, 16'h8000, 8'h00, 17'h0},      // R10
    {2'd3, 4'd10, 16'hC000, 8'h00, 17'h0},
    {2'd3, 4'd10, 16'hBFFF, 8'h00, 17'h1},
    {2'd3, 4'd10, 16'h0000, 8'h00, 17'h2},
    {2'd3, 4'd10, 16'h7FFF, 8'h00, 17'h2}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic              wr_i = 1'b0;
  logic [ROM_AW-1:0] rom_addr_o;
  logic              rom_sel_o, ram_sel_o;
  logic [7:0]        rdata_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  nibble_bank_mapper #(.ROM_AW(ROM_AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rom_addr_o(rom_addr_o), .rom_sel_o(rom_sel_o),
    .ram_sel_o(ram_sel_o), .rdata_o(rdata_o)
  );

  task automatic check(input int req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%h actual=%h expected=%h", req, addr_i, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int req, input int op, input logic [16:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    case (op)
      1: check(req, {9'd0, rdata_o}, exp);
      2: check(req, rom_addr_o, exp);
      default: check(req, {15'd0, rom_sel_o, ram_sel_o}, exp);
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46:45] == 2'd0) wr(VEC[i][40:25], VEC[i][24:17]);
      else rd(VEC[i][40:25], int'(VEC[i][44:41]), int'(VEC[i][46:45]), VEC[i][16:0]);
    end
    // R1 R6: every bank value, including fold-over
    for (int b = 0; b < 16; b++) begin
      int bb;
      bb = (b == 0) ? 1 : b;
      wr(16'h2100, 8'h30 | 8'(b));
      rd(16'h4000 + 16'(b), 6, 2, 17'((bb * 32'h4000 + b) & 32'h1FFFF));
    end
    // R3 R5: fill 16 entries, read back through another mirror
    wr(16'h000A, 8'h0A);
    for (int i = 0; i < 16; i++) wr(16'hA100 + 16'(i), 8'h50 | 8'(i));
    for (int i = 0; i < 16; i++) rd(16'hB300 + 16'(i), 3, 1, 17'(8'hF0 | 8'(i)));
    // R9: asynchronous reset mid-run, contents kept
    wr(16'h2100, 8'h07);
    @(negedge clk_i);
    rst_ni = 1'b0;
    rd(16'h4000, 9, 2, 17'h04000);
    rd(16'hA105, 9, 1, 17'h000FF);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr(16'h0000, 8'h0A);
    rd(16'hA105, 9, 1, 17'h000F5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule